// File: doc/BRIEF.md
# Masked interrupt status aggregator

This block gathers three interrupt sources into one 8-bit status register and drives a single active-low interrupt request line towards a host. Bit 0 of the status register follows the level of a DSP interrupt pin, after a synchronizer. Bit 6 latches a FIFO-switch event. Bit 7 latches a bus-timeout event. An 8-bit mask register enables each status bit at the same position. The request line is pulled low while any enabled status bit is set.

The host reaches the block through a small register port with four addresses. It can read the status register, and it can read and write the mask register. The two sticky bits are cleared by writing self-clearing pulse bits to a control register. A read of the DSP interrupt register returns the DSP level and sends a one-cycle acknowledge pulse to the DSP, which then drops its pin. The block does not decode the host bus, and it does not produce the source events.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, irq_n is high, the mask register reads 0x00, and the status register reads 0x00 while the DSP pin is low.
- R2: Status bit 0 equals the level of dsp_irq_pin delayed by SYNC_STAGES clock edges. Status bits 1 to 5 always read zero.
- R3: A one-cycle pulse on fifo_switch_evt sets status bit 6 (value 0x40). The bit stays set until it is cleared through the control register.
- R4: A one-cycle pulse on bus_timeout_evt sets status bit 7 (value 0x80). The bit stays set until it is cleared through the control register.
- R5: The register map is: address 0 is status (read only), 1 is mask (read/write, all 8 bits), 2 is control (write only), 3 is the DSP interrupt register (read only). Read data is registered: it appears in the cycle after reg_rd and holds until the next read.
- R6: irq_n goes low one cycle after a cycle in which (status AND mask) is nonzero, and is high otherwise. Mask bits 1 to 5 have no effect on irq_n.
- R7: Writing the control register with bit 0 set clears status bit 6, and with bit 1 set clears status bit 7. The two clears act independently, and the control register reads 0x00.
- R8: If a source event and its clear arrive in the same cycle, the status bit ends up set.
- R9: A read of address 3 returns {7'b0, status bit 0} and raises dsp_ack for exactly the next cycle. Reads of other addresses raise no dsp_ack.
- R10: Writes to address 0 and address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dsp_irq_pin | input | 1 | DSP interrupt level, asynchronous |
| fifo_switch_evt | input | 1 | Single-cycle FIFO-switch event |
| bus_timeout_evt | input | 1 | Single-cycle bus-timeout event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| dsp_ack | output | 1 | One-cycle acknowledge pulse to the DSP |
| irq_n | output | 1 | Active-low interrupt request to the host |

## Verification
The bench builds the block with SYNC_STAGES = 2 and RST_STAGES = 2, the default values. With these values the two-edge pin latency can be observed directly, so a read placed right at the latency boundary shows whether bit 0 uses the synchronized level. A short reset chain lets directed cases begin soon after reset. Random traffic then mixes pin toggles, events and clears, so that same-cycle collisions between an event and its clear occur many times.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned STAT_W       = 8;
  localparam int unsigned DSP_POS      = 0;
  localparam int unsigned FIFO_POS     = 6;
  localparam int unsigned TMO_POS      = 7;
  localparam int unsigned NUM_STICKY   = 2;
  localparam int unsigned CLR_FIFO_POS = 0;
  localparam int unsigned CLR_TMO_POS  = 1;

  typedef enum logic [1:0] {
    ADR_STATUS = 2'd0,
    ADR_MASK   = 2'd1,
    ADR_CTRL   = 2'd2,
    ADR_DSP    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = (chain_q << 1) | STAGES'(1);
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = (chain_q << 1) | STAGES'(din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic d;

  // A set arriving together with a clear keeps the bit set.
  always_comb begin
    d = set_i | (q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dsp_irq_pin,
  input  logic       fifo_switch_evt,
  input  logic       bus_timeout_evt,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       dsp_ack,
  output logic       irq_n
);
  logic                  rst_n_s;
  logic                  dsp_lvl;
  logic [NUM_STICKY-1:0] sticky_set;
  logic [NUM_STICKY-1:0] sticky_clr;
  logic [NUM_STICKY-1:0] sticky_q;
  logic                  clr_fifo;
  logic                  clr_tmo;
  logic [STAT_W-1:0]     status_w;
  logic [STAT_W-1:0]     mask_q,  mask_d;
  logic [STAT_W-1:0]     rdata_q, rdata_d;
  logic                  ack_q,   ack_d;
  logic                  irqn_q,  irqn_d;
  logic                  wr_mask, wr_ctrl, rd_dsp;
  reg_addr_e             addr_e;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_s)
  );

  irq_level_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n_s), .din(dsp_irq_pin), .dout(dsp_lvl)
  );

  always_comb begin
    addr_e   = reg_addr_e'(reg_addr);
    wr_mask  = reg_wr & (addr_e == ADR_MASK);
    wr_ctrl  = reg_wr & (addr_e == ADR_CTRL);
    rd_dsp   = reg_rd & (addr_e == ADR_DSP);
    clr_fifo = wr_ctrl & reg_wdata[CLR_FIFO_POS];
    clr_tmo  = wr_ctrl & reg_wdata[CLR_TMO_POS];
    sticky_set = {bus_timeout_evt, fifo_switch_evt};
    sticky_clr = {clr_tmo, clr_fifo};
  end

  for (genvar gi = 0; gi < NUM_STICKY; gi++) begin : g_sticky
    irq_sticky_bit u_bit (
      .clk(clk), .rst_n(rst_n_s),
      .set_i(sticky_set[gi]), .clr_i(sticky_clr[gi]), .q(sticky_q[gi])
    );
  end

  always_comb begin
    status_w           = '0;
    status_w[DSP_POS]  = dsp_lvl;
    status_w[FIFO_POS] = sticky_q[0];
    status_w[TMO_POS]  = sticky_q[1];
  end

  always_comb begin
    mask_d = wr_mask ? reg_wdata : mask_q;
    ack_d  = rd_dsp;
    irqn_d = ~|(status_w & mask_q);
    rdata_d = rdata_q;
    if (reg_rd) begin
      unique case (addr_e)
        ADR_STATUS: rdata_d = status_w;
        ADR_MASK:   rdata_d = mask_q;
        ADR_CTRL:   rdata_d = '0;
        ADR_DSP:    rdata_d = STAT_W'(dsp_lvl);
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mask_q  <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
      irqn_q  <= 1'b1;
    end else begin
      mask_q  <= mask_d;
      rdata_q <= rdata_d;
      ack_q   <= ack_d;
      irqn_q  <= irqn_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign dsp_ack   = ack_q;
  assign irq_n     = irqn_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
  input logic       clk,
  input logic       rst_n_s,
  input logic       fifo_switch_evt,
  input logic       bus_timeout_evt,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic       dsp_ack,
  input logic       irq_n,
  input logic [1:0] sticky_q,
  input logic       clr_fifo,
  input logic       clr_tmo,
  input logic [7:0] mask_q
);
  // R3: the FIFO-switch bit holds while no clear arrives
  a_r3_fifo_holds: assert property (@(posedge clk) disable iff (!rst_n_s)
    sticky_q[0] && !clr_fifo |=> sticky_q[0]);

  // R4: a timeout event sets its bit
  a_r4_tmo_set: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_timeout_evt |=> sticky_q[1]);

  // R7: a clear without a colliding event empties the bit
  a_r7_fifo_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    clr_fifo && !fifo_switch_evt |=> !sticky_q[0]);

  a_r7_tmo_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    clr_tmo && !bus_timeout_evt |=> !sticky_q[1]);

  // R8: the event wins over its clear
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n_s)
    fifo_switch_evt && clr_fifo |=> sticky_q[0]);

  // R9: an acknowledge comes only from a read of the DSP register
  a_r9_ack_source: assert property (@(posedge clk) disable iff (!rst_n_s)
    dsp_ack |-> $past(reg_rd && reg_addr == 2'd3));

  // R6: a fully cleared mask keeps the request line high
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    mask_q == 8'h00 |=> irq_n);
endmodule

bind irq_status_agg irq_status_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s),
  .fifo_switch_evt(fifo_switch_evt), .bus_timeout_evt(bus_timeout_evt),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .dsp_ack(dsp_ack), .irq_n(irq_n),
  .sticky_q(sticky_q), .clr_fifo(clr_fifo), .clr_tmo(clr_tmo), .mask_q(mask_q)
);

// File: tb/sim_irq_status_agg.sv
module sim_irq_status_agg;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, fevt = 1'b0, tevt = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic ack, irq_n;

  int vec = 0, miss = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_agg #(.SYNC_STAGES(SYNC), .RST_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .dsp_irq_pin(pin), .fifo_switch_evt(fevt),
    .bus_timeout_evt(tevt), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .dsp_ack(ack), .irq_n(irq_n)
  );

  // Reference model built from the requirements
  logic [SYNC-1:0] m_sync;
  logic m_fifo, m_tmo, m_ack, m_irqn;
  logic [7:0] m_mask, m_rdata;
  logic [1:0] m_last;

  function automatic logic [7:0] m_status(logic s0, logic f, logic t);
    return {t, f, 5'b0, s0};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= '0; m_fifo <= 0; m_tmo <= 0; m_ack <= 0; m_irqn <= 1;
      m_mask <= 0; m_rdata <= 0; m_last <= 0;
    end else begin
      m_sync <= {m_sync[SYNC-2:0], pin};
      m_fifo <= fevt | (m_fifo & ~(wr && addr == 2 && wdata[0]));
      m_tmo  <= tevt | (m_tmo  & ~(wr && addr == 2 && wdata[1]));
      if (wr && addr == 1) m_mask <= wdata;
      m_irqn <= ((m_status(m_sync[SYNC-1], m_fifo, m_tmo) & m_mask) == 0);
      m_ack  <= rd && addr == 3;
      if (rd) begin
        m_last <= addr;
        case (addr)
          2'd0: m_rdata <= m_status(m_sync[SYNC-1], m_fifo, m_tmo);
          2'd1: m_rdata <= m_mask;
          2'd2: m_rdata <= 8'h00;
          default: m_rdata <= {7'b0, m_sync[SYNC-1]};
        endcase
      end
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check("R6 irq_n model", {7'b0, irq_n}, {7'b0, m_irqn});
      check("R9 dsp_ack model", {7'b0, ack}, {7'b0, m_ack});
      case (m_last)
        2'd0: check("R2 status read model", rdata, m_rdata);
        2'd1: check("R5 mask read model", rdata, m_rdata);
        2'd2: check("R7 control read model", rdata, m_rdata);
        default: check("R9 dsp read model", rdata, m_rdata);
      endcase
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    wr = 1; addr = a; wdata = d; cyc(); wr = 0;
  endtask

  task automatic rreg(logic [1:0] a);
    rd = 1; addr = a; cyc(); rd = 0;
  endtask

  task automatic pulse_f(); fevt = 1; cyc(); fevt = 0; endtask
  task automatic pulse_t(); tevt = 1; cyc(); tevt = 0; endtask

  initial begin
    cyc(3); rst_n = 1; cyc(4);
    chk_on = 1;
    // R1: reset state
    check("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
    rreg(0); check("R1 status after reset", rdata, 8'h00);
    rreg(1); check("R1 mask after reset", rdata, 8'h00);

    // R3 / R6 / R7: FIFO-switch event
    pulse_f(); rreg(0); check("R3 fifo bit set", rdata, 8'h40);
    check("R6 masked source quiet", {7'b0, irq_n}, 8'h01);
    wreg(1, 8'h40); cyc();
    check("R6 enabled source asserts", {7'b0, irq_n}, 8'h00);
    cyc(3); rreg(0); check("R3 fifo bit sticky", rdata, 8'h40);
    wreg(2, 8'h01); cyc();
    check("R7 irq released after clear", {7'b0, irq_n}, 8'h01);
    rreg(0); check("R7 fifo bit cleared", rdata, 8'h00);

    // R4 / R7: timeout event and clear independence
    pulse_t(); rreg(0); check("R4 timeout bit set", rdata, 8'h80);
    wreg(1, 8'hC0); cyc();
    check("R6 timeout asserts", {7'b0, irq_n}, 8'h00);
    wreg(2, 8'h01); rreg(0); check("R7 wrong clear no effect", rdata, 8'h80);
    wreg(2, 8'h02); rreg(0); check("R7 timeout cleared", rdata, 8'h00);
    rreg(2); check("R7 control reads zero", rdata, 8'h00);

    // R8: event and clear in one cycle
    fevt = 1; wreg(2, 8'h01); fevt = 0;
    rreg(0); check("R8 event wins", rdata, 8'h40);
    tevt = 1; wreg(2, 8'h03); tevt = 0;
    rreg(0); check("R8 timeout wins, fifo cleared", rdata, 8'h80);
    wreg(2, 8'h03);

    // R2: pin latency
    pin = 1; cyc(); rreg(0); check("R2 pin not yet through", rdata, 8'h00);
    rreg(0); check("R2 pin after sync", rdata, 8'h01);
    // R6: unused mask bits have no effect
    wreg(1, 8'h3E); cyc(2);
    check("R6 unused mask bits ignored", {7'b0, irq_n}, 8'h01);
    // R9: DSP register read and acknowledge
    rreg(3); check("R9 dsp read data", rdata, 8'h01);
    check("R9 ack raised", {7'b0, ack}, 8'h01);
    cyc(); check("R9 ack one cycle", {7'b0, ack}, 8'h00);
    pin = 0;
    rreg(1); check("R9 no ack on mask read", {7'b0, ack}, 8'h00);
    // R10: writes to read-only addresses
    wreg(0, 8'hFF); wreg(3, 8'hFF);
    rreg(1); check("R10 mask unchanged", rdata, 8'h3E);
    rreg(0); check("R10 status unchanged", rdata, 8'h00);

    // Random phase, fixed seed
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom();
      if (r[2:0] == 0) pin = ~pin;
      fevt = (r[6:3] == 0);
      tevt = (r[10:7] == 1);
      wr = 0; rd = 0;
      case (r[13:11])
        3'd0, 3'd1: begin rd = 1; addr = r[15:14]; end
        3'd2: begin wr = 1; addr = 2'd1; wdata = r[23:16]; end
        3'd3: begin wr = 1; addr = 2'd2; wdata = r[23:16]; end
        3'd4: begin wr = 1; addr = r[15:14]; wdata = r[23:16]; end
        default: ;
      endcase
      cyc();
    end
    fevt = 0; tevt = 0; wr = 0; rd = 0;
    cyc(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end
endmodule